// File: doc/BRIEF.md
# Interrupt Pin Delivery Engine

This block turns activity on a bank of interrupt input pins into interrupt messages for local interrupt controllers. Sources report per-pin events: assert, deassert, or a pulse, which is an assert and a deassert folded into one cycle. Several sources may share one pin, so each pin keeps a signed count of outstanding asserts. A delivery attempt happens only when that count steps from zero to one. A count that drops below zero is reported as an error.

Each pin has a routing entry. The entry holds the vector, the delivery mode, physical or logical addressing, the trigger type, a mask bit and a 15-bit destination. For level-triggered pins the block keeps a remote-pending flag. While that flag is set, further deliveries are held back. An end-of-interrupt notice carrying a vector clears the flag on every matching pin, and any of those pins that is still asserted fires again. Rewriting an entry also causes a new attempt when the pin ends up level-triggered and still asserted.

Accepted attempts set a per-pin pending bit. Pending pins are offered on a valid/ready message port, lowest pin number first.

Top module: `irq_pin_engine`

## Requirements
- R1: After reset no message is offered and every remote-pending bit, `ev_err` and `cnt_err` are 0. Every entry resets masked, so an assert on a pin that has not been written produces no message.
- R2: An assert event (`ev_kind`=0) adds one to the pin count and a deassert (`ev_kind`=1) subtracts one. A delivery attempt is made only when the count goes from 0 to 1, so a second assert on a shared pin sends nothing.
- R3: When an event leaves a pin's count below zero, `cnt_err` is 1 in the following cycle. A later assert that only brings the count back to zero does not deliver.
- R4: A pulse event (`ev_kind`=2) attempts delivery when the count was 0 and leaves the count unchanged.
- R5: When the entry's mask bit (bit 13) is set at the moment of the attempt, no message is sent and the remote-pending bit is not set.
- R6: For a level pin (entry bit 12 = 1), a successful attempt sets the pin's bit in `rirr`. An attempt made while that bit is set is suppressed. Edge pins never set it.
- R7: The entry layout is vector [7:0], delivery mode [10:8], logical addressing [11], level trigger [12], mask [13] and destination [28:14]. A message carries these fields, with `msg_phys` equal to the inverse of bit 11 and `msg_level` equal to bit 12.
- R8: An EOI with vector V clears `rirr` on every pin whose remote-pending bit is set and whose vector is V. Each such pin whose count is above zero is delivered again. An EOI with another vector changes nothing.
- R9: An entry write that makes a pin edge-triggered clears its `rirr` bit. An entry write that leaves a pin level-triggered while its count is above zero makes a delivery attempt.
- R10: An event whose pin index is not below 32 sets `ev_err` in the next cycle and changes no state.
- R11: A pending message stays offered until `msg_ready` accepts it. When several pins are pending, the lowest pin number is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Pin event strobe |
| ev_kind | input | 2 | 0 assert, 1 deassert, 2 pulse |
| ev_pin | input | 6 | Pin index of the event |
| ev_err | output | 1 | Previous event named a pin out of range |
| cnt_err | output | 1 | Previous event drove a count negative |
| ent_we | input | 1 | Entry write strobe |
| ent_pin | input | 5 | Pin whose entry is written |
| ent_data | input | 29 | New entry contents |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being retired |
| rirr | output | 32 | Remote-pending bit per pin |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver takes the offered message |
| msg_vec | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_phys | output | 1 | 1 for physical addressing |
| msg_level | output | 1 | 1 for a level-triggered source |
| msg_dest | output | 15 | Message destination |

## Verification
The bench drives a single assert on a fresh pin and compares every message field. It then repeats asserts on a shared pin to separate a zero-to-one step from later steps. It drives deasserts from zero, to show that counts go negative rather than saturating at zero. Back-to-back pulses show that a pulse fires without leaving the count raised. Level pins are exercised with EOIs that carry a matching and a non-matching vector, with the pin both still asserted and released. Two level pins that share one vector and are raised in reverse order test the lowest-first ordering and the one-cycle EOI over several pins.

// File: rtl/irq_pin_engine.sv
module irq_pin_engine #(
  parameter int NPINS = 32,
  parameter int CW    = 8,
  localparam int PW   = $clog2(NPINS),
  localparam int EW   = PW + 1,
  localparam int TW   = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [EW-1:0]    ev_pin,
  output logic             ev_err,
  output logic             cnt_err,
  input  logic             ent_we,
  input  logic [PW-1:0]    ent_pin,
  input  logic [TW-1:0]    ent_data,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vec,
  output logic [NPINS-1:0] rirr,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_vec,
  output logic [2:0]       msg_dmode,
  output logic             msg_phys,
  output logic             msg_level,
  output logic [14:0]      msg_dest
);
  localparam logic [1:0] K_ASSERT = 2'd0, K_DEASSERT = 2'd1, K_PULSE = 2'd2;

  logic [NPINS-1:0][TW-1:0] ent_w;
  logic [NPINS-1:0] pend, fire, rirr_nx, neg;
  logic [PW-1:0] sel;
  logic [TW-1:0] cur;
  logic ev_ok;

  assign ev_ok = ev_valid && (ev_pin < EW'(NPINS));

  for (genvar g = 0; g < NPINS; g++) begin : gen_pin
    logic [TW-1:0] e_q, e_nx;
    logic signed [CW-1:0] c_q, c_up, c_dn, c_nx;
    logic hit, we, lvl, rise, n_loc, eoi_hit, pos, r_a, try_go;

    assign hit  = ev_ok && (ev_pin == EW'(g));
    assign we   = ent_we && (ent_pin == PW'(g));
    assign e_nx = we ? ent_data : e_q;
    assign lvl  = e_nx[12];
    assign c_up = c_q + CW'(1);
    assign c_dn = c_q - CW'(1);

    always_comb begin
      c_nx  = c_q;
      rise  = 1'b0;
      n_loc = 1'b0;
      if (hit) begin
        case (ev_kind)
          K_ASSERT:   begin c_nx = c_up; rise = (c_q == '0); n_loc = c_up[CW-1]; end
          K_DEASSERT: begin c_nx = c_dn; n_loc = c_dn[CW-1]; end
          K_PULSE:    begin rise = (c_q == '0); n_loc = c_up[CW-1] | c_q[CW-1]; end
          default:    ;
        endcase
      end
    end

    assign eoi_hit = eoi_valid && rirr[g] && (e_nx[7:0] == eoi_vec);
    assign pos     = !c_nx[CW-1] && (c_nx != '0);
    assign r_a     = rirr[g] && !(we && !lvl) && !eoi_hit;
    assign try_go  = rise | ((eoi_hit | (we && lvl)) && pos);
    assign fire[g]    = try_go && !e_nx[13] && !(lvl && r_a);
    assign rirr_nx[g] = r_a | (fire[g] & lvl);
    assign neg[g]     = n_loc;
    assign ent_w[g]   = e_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_q <= TW'(1) << 13;
        c_q <= '0;
      end else begin
        e_q <= e_nx;
        if (hit) c_q <= c_nx;
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (pend[i]) sel = PW'(i);
  end

  assign msg_valid = |pend;
  assign cur       = ent_w[sel];
  assign msg_vec   = cur[7:0];
  assign msg_dmode = cur[10:8];
  assign msg_phys  = !cur[11];
  assign msg_level = cur[12];
  assign msg_dest  = cur[28:14];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      rirr    <= '0;
      ev_err  <= 1'b0;
      cnt_err <= 1'b0;
    end else begin
      pend    <= (pend & ~((msg_valid && msg_ready) ? (NPINS'(1) << sel) : '0)) | fire;
      rirr    <= rirr_nx;
      ev_err  <= ev_valid && !ev_ok;
      cnt_err <= |neg;
    end
  end

  // R11
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid);
  // R6
  rirr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr & ~$past(rirr) & ~pend) == '0);
  // R8
  rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rirr & $past(rirr)) != '0) |-> ($past(eoi_valid) || $past(ent_we)));
  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> $past(ev_valid));
  // R3
  neg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |-> $past(ev_valid));
endmodule

// File: tb/tb_irq_pin_engine.sv
module tb_irq_pin_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ent_we = 1'b0, eoi_valid = 1'b0, msg_ready = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [5:0] ev_pin = '0;
  logic [4:0] ent_pin = '0;
  logic [28:0] ent_data = '0;
  logic [7:0] eoi_vec = '0;
  logic ev_err, cnt_err, msg_valid, msg_phys, msg_level;
  logic [31:0] rirr;
  logic [7:0] msg_vec;
  logic [2:0] msg_dmode;
  logic [14:0] msg_dest;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_pin_engine dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_pin(ev_pin),
    .ev_err(ev_err), .cnt_err(cnt_err), .ent_we(ent_we), .ent_pin(ent_pin),
    .ent_data(ent_data), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .rirr(rirr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
    .msg_dmode(msg_dmode), .msg_phys(msg_phys), .msg_level(msg_level), .msg_dest(msg_dest)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [28:0] mk(input logic [7:0] v, input logic [2:0] dm,
                                     input logic logi, input logic lvl, input logic msk,
                                     input logic [14:0] d);
    return {d, msk, lvl, logi, dm, v};
  endfunction

  task automatic prog(input int pin, input logic [28:0] e);
    @(negedge clk); ent_we = 1'b1; ent_pin = 5'(pin); ent_data = e;
    @(negedge clk); ent_we = 1'b0;
  endtask

  task automatic pin_ev(input logic [1:0] k, input int pin);
    @(negedge clk); ev_valid = 1'b1; ev_kind = k; ev_pin = 6'(pin);
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vec = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic take(input string req, input logic [14:0] d, input logic [7:0] v);
    chk(req, "msg_valid", msg_valid, 1);
    chk(req, "msg_dest", msg_dest, d);
    chk(req, "msg_vec", msg_vec, v);
    msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "msg_valid", msg_valid, 0);
    chk("R1", "rirr", rirr, 0);
    chk("R1", "ev_err", ev_err, 0);
    chk("R1", "cnt_err", cnt_err, 0);
    pin_ev(2'd0, 3);
    chk("R1", "masked default msg_valid", msg_valid, 0);
    pin_ev(2'd1, 3);
  endtask

  task automatic t_edge;
    prog(5, mk(8'h41, 3'd1, 1'b1, 1'b0, 1'b0, 15'h2A3C));
    pin_ev(2'd0, 5);
    chk("R7", "msg_dmode", msg_dmode, 1);
    chk("R7", "msg_phys", msg_phys, 0);
    chk("R7", "msg_level", msg_level, 0);
    take("R7", 15'h2A3C, 8'h41);
    chk("R2", "drained", msg_valid, 0);
    pin_ev(2'd0, 5);
    chk("R2", "shared second assert", msg_valid, 0);
    pin_ev(2'd1, 5);
    pin_ev(2'd1, 5);
    chk("R2", "after deasserts", msg_valid, 0);
    chk("R6", "edge pin rirr", rirr[5], 0);
    pin_ev(2'd0, 5);
    take("R2", 15'h2A3C, 8'h41);
    pin_ev(2'd1, 5);
  endtask

  task automatic t_negative;
    prog(6, mk(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 15'h0006));
    pin_ev(2'd1, 6);
    chk("R3", "cnt_err", cnt_err, 1);
    pin_ev(2'd0, 6);
    chk("R3", "back to zero no msg", msg_valid, 0);
    chk("R3", "cnt_err cleared", cnt_err, 0);
    pin_ev(2'd0, 6);
    take("R3", 15'h0006, 8'h44);
    pin_ev(2'd1, 6);
  endtask

  task automatic t_pulse;
    prog(7, mk(8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 15'h0007));
    pin_ev(2'd2, 7);
    take("R4", 15'h0007, 8'h50);
    pin_ev(2'd2, 7);
    take("R4", 15'h0007, 8'h50);
    pin_ev(2'd0, 7);
    take("R4", 15'h0007, 8'h50);
    pin_ev(2'd1, 7);
  endtask

  task automatic t_mask;
    prog(8, mk(8'h58, 3'd0, 1'b0, 1'b1, 1'b1, 15'h0008));
    pin_ev(2'd0, 8);
    chk("R5", "masked msg_valid", msg_valid, 0);
    chk("R5", "masked rirr", rirr[8], 0);
    pin_ev(2'd1, 8);
  endtask

  task automatic t_level;
    prog(9, mk(8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 15'h0003));
    pin_ev(2'd0, 9);
    chk("R6", "rirr set", rirr[9], 1);
    chk("R7", "msg_level", msg_level, 1);
    chk("R7", "msg_phys", msg_phys, 1);
    take("R6", 15'h0003, 8'h60);
    pin_ev(2'd1, 9);
    pin_ev(2'd0, 9);
    chk("R6", "suppressed", msg_valid, 0);
    eoi(8'h61);
    chk("R8", "other vector rirr", rirr[9], 1);
    chk("R8", "other vector msg", msg_valid, 0);
    eoi(8'h60);
    chk("R8", "redeliver rirr", rirr[9], 1);
    take("R8", 15'h0003, 8'h60);
    pin_ev(2'd1, 9);
    eoi(8'h60);
    chk("R8", "released rirr", rirr[9], 0);
    chk("R8", "released msg", msg_valid, 0);
  endtask

  task automatic t_write;
    prog(10, mk(8'h70, 3'd0, 1'b0, 1'b1, 1'b1, 15'h000A));
    pin_ev(2'd0, 10);
    chk("R9", "masked first", msg_valid, 0);
    prog(10, mk(8'h70, 3'd0, 1'b0, 1'b1, 1'b0, 15'h000A));
    chk("R9", "rewrite rirr", rirr[10], 1);
    take("R9", 15'h000A, 8'h70);
    prog(10, mk(8'h70, 3'd0, 1'b0, 1'b0, 1'b0, 15'h000A));
    chk("R9", "edge clears rirr", rirr[10], 0);
    chk("R9", "edge no msg", msg_valid, 0);
    pin_ev(2'd1, 10);
  endtask

  task automatic t_priority;
    prog(11, mk(8'h33, 3'd0, 1'b0, 1'b1, 1'b0, 15'd11));
    prog(12, mk(8'h33, 3'd0, 1'b0, 1'b1, 1'b0, 15'd12));
    pin_ev(2'd0, 12);
    chk("R11", "first dest", msg_dest, 12);
    pin_ev(2'd0, 11);
    take("R11", 15'd11, 8'h33);
    take("R11", 15'd12, 8'h33);
    chk("R11", "drained", msg_valid, 0);
    eoi(8'h33);
    chk("R8", "both rirr", rirr[12:11], 2'b11);
    take("R8", 15'd11, 8'h33);
    take("R8", 15'd12, 8'h33);
    pin_ev(2'd1, 11);
    pin_ev(2'd1, 12);
    eoi(8'h33);
    chk("R8", "both cleared", rirr[12:11], 2'b00);
  endtask

  task automatic t_range;
    pin_ev(2'd0, 40);
    chk("R10", "ev_err", ev_err, 1);
    chk("R10", "no msg", msg_valid, 0);
    pin_ev(2'd2, 32);
    chk("R10", "ev_err 32", ev_err, 1);
    chk("R10", "rirr untouched", rirr, 0);
    pin_ev(2'd0, 31);
    chk("R10", "in range no err", ev_err, 0);
    pin_ev(2'd1, 31);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_negative();
    t_pulse();
    t_mask();
    t_level();
    t_write();
    t_priority();
    t_range();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule